// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous internal request port to an external asynchronous static RAM of 131,072 words of 16 bits. A requester presents a 17-bit word address, a write flag, two active-high byte-lane enables and write data. The controller drives the memory's control pins and a 16-bit data bus whose drivers it switches on and off itself, and returns read data with a one-clock completion pulse.

The memory has no clock, so each phase lasts a whole number of system clocks. That number comes from nanosecond parameters divided by the clock period and rounded up, with at least one clock per phase. The address only moves while every strobe is inactive. Output enable stays high for the whole of a write. The write data drivers turn on one guard clock after write enable falls and turn off one clock after it rises, so the memory and the controller never drive the bus at the same time.

Top module: `sram_if_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_done` is 0, `mem_cs_n`, `mem_wr_n`, `mem_rd_n`, `mem_lo_n` and `mem_hi_n` are 1, and `mem_cs2` and `mem_dq_oe` are 0.
- R2: A request is taken only when `req_ready` is 1, `req_valid` is 1 and at least one bit of `req_lanes` is set. A request with `req_lanes` = 0 starts no memory cycle. `req_ready` is 0 from the cycle after acceptance until the transaction completes.
- R3: `mem_addr` changes only at a clock edge where, in the cycle before and in the cycle after, `mem_cs_n`, `mem_wr_n`, `mem_lo_n` and `mem_hi_n` are 1 and `mem_cs2` is 0.
- R4: The memory is selected (`mem_cs_n` = 0 together with `mem_cs2` = 1) only while a read strobe (`mem_rd_n` = 0) or a write strobe (`mem_wr_n` = 0) is active.
- R5: A read holds `mem_rd_n` low and `mem_wr_n` high for exactly RD_CLKS = max(ceil(T_AA/CLK), ceil(T_RC/CLK), ceil(T_OE/CLK)) clocks. The bus value is captured at the end of the last of those clocks. Lanes not requested read back as zero. With the defaults RD_CLKS = 11, and `rsp_done` is seen RD_CLKS+2 cycles after the accepting edge.
- R6: During an active phase, `mem_lo_n` is 0 exactly when `req_lanes[0]` was set (data bits 7:0), and `mem_hi_n` is 0 exactly when `req_lanes[1]` was set (bits 15:8).
- R7: A write holds `mem_wr_n` low for exactly WR_CLKS = max(ceil(T_WP/CLK), 1+ceil(T_DW/CLK), ceil(T_WC/CLK), ceil(T_AW/CLK)) clocks, and `mem_rd_n` stays high throughout. With the defaults WR_CLKS = 11, and `rsp_done` is seen WR_CLKS+3 cycles after the accepting edge.
- R8: `mem_dq_oe` rises one clock after `mem_wr_n` falls. It stays high for WR_CLKS clocks, ending one clock after `mem_wr_n` rises. It is never high while `mem_rd_n` is 0. While it is high, `mem_dq_out` carries the write data.
- R9: `rsp_done` is a single-cycle pulse per transaction, in the first idle cycle after the read capture or the write release.
- R10: `mem_wr_n` and `mem_rd_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_lanes | input | 2 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, a request can be taken |
| rsp_rdata | output | 16 | Captured read data, unrequested lanes zero |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory word address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_cs2 | output | 1 | Memory second chip select, active high |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_lo_n | output | 1 | Lower byte select, active low |
| mem_hi_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory bus |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the memory bus value on `mem_dq_in` only matters in the clock where it is captured. Nothing is assumed about the request inputs. Unqualified or badly timed requests must be ignored by the controller itself, so the stimulus includes a request with no lanes set and raises `req_valid` only in idle cycles. The bench's memory model returns zero on lanes that are not selected or that the output enable does not drive.

// File: rtl/sram_if_pkg.sv
// Package: shared state type and the clock-count helpers used to size each
// memory phase from nanosecond parameters.
package sram_if_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WREL  = 3'd4
    } seq_state_t;

    // Whole clocks that cover ns, never fewer than one.
    function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase timer: a down-counter loaded at the start of a memory phase.
// `last` is high during the final clock of the phase.
// Assumes load_val >= 1.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load length-1 at phase start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_if_datapath.sv
// Datapath: holds the address, direction, lanes and write data of the
// accepted request, and captures read data with unrequested lanes zeroed.
// Assumes DATA_W is a multiple of 8.
module sram_if_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Register the request fields when the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            lanes_q <= req_lanes;
            wdata_q <= req_wdata;
        end
    end

    // One capture register per byte lane, cleared when the lane was not requested.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)       rdata_q[8*l +: 8] <= '0;
            else if (capture) rdata_q[8*l +: 8] <= lanes_q[l] ? mem_dq_in[8*l +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_seq_fsm.sv
// Sequencer: walks idle -> address -> read or write pulse -> release and
// drives registered memory strobes from the next state, so every pin
// changes only at a clock edge. Assumes WR_CLKS >= 2 (guard clock).
module sram_seq_fsm
    import sram_if_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int CNT_W   = 4,
    parameter int RD_CLKS = 11,
    parameter int WR_CLKS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LANES-1:0] req_lanes,
    input  logic             wr_q,
    input  logic [LANES-1:0] lanes_q,
    input  logic             last,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output logic             cs_n,
    output logic             cs2,
    output logic             wr_n,
    output logic             rd_n,
    output logic [LANES-1:0] sel_n,
    output logic             dq_oe
);
    seq_state_t state_q, nxt;
    logic       act;

    assign ready    = (state_q == ST_IDLE);
    assign accept   = ready && req_valid && (|req_lanes);
    assign load     = (state_q == ST_ADDR);
    assign load_val = wr_q ? CNT_W'(WR_CLKS) : CNT_W'(RD_CLKS);
    assign capture  = (state_q == ST_READ) && last;
    assign act      = (nxt == ST_READ) || (nxt == ST_WRITE);

    // Next-state selection.
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) nxt = ST_ADDR;
            ST_ADDR:  nxt = wr_q ? ST_WRITE : ST_READ;
            ST_READ:  if (last) nxt = ST_IDLE;
            ST_WRITE: if (last) nxt = ST_WREL;
            ST_WREL:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register and registered strobes derived from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n    <= 1'b1;
            cs2     <= 1'b0;
            wr_n    <= 1'b1;
            rd_n    <= 1'b1;
            sel_n   <= '1;
            dq_oe   <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= nxt;
            cs_n    <= !act;
            cs2     <= act;
            wr_n    <= !(nxt == ST_WRITE);
            rd_n    <= !(nxt == ST_READ);
            sel_n   <= act ? ~lanes_q : '1;
            dq_oe   <= ((nxt == ST_WRITE) && (state_q == ST_WRITE)) || (nxt == ST_WREL);
            done    <= capture || (state_q == ST_WREL);
        end
    end

    // Checker counters: length of the current write and read strobe.
    logic [CNT_W-1:0] wr_lo_cnt, rd_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lo_cnt <= '0;
            rd_lo_cnt <= '0;
        end else begin
            wr_lo_cnt <= wr_n ? '0 : wr_lo_cnt + 1'b1;
            rd_lo_cnt <= rd_n ? '0 : rd_lo_cnt + 1'b1;
        end
    end

    // R7
    wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_lo_cnt == CNT_W'(WR_CLKS)));
    // R5
    rd_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_lo_cnt == CNT_W'(RD_CLKS)));
    // R10
    no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));
    // R8
    drive_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (!wr_n && $past(!wr_n)));
    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> rd_n);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    select_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs2) |-> (!wr_n || !rd_n));
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
endmodule

// File: rtl/sram_if_ctrl.sv
// Top: asynchronous SRAM interface controller. Sizes the read and write
// phases from nanosecond timing parameters and wires the request register,
// phase timer and sequencer to the memory pins. Assumes a 16-bit memory with
// two byte lanes and a synchronous active-low reset held for one edge or more.
module sram_if_ctrl
    import sram_if_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int CLK_NS  = 5,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 30,
    parameter int T_WC_NS = 55,
    parameter int T_AW_NS = 50,
    parameter int T_WP_NS = 45,
    parameter int T_DW_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_lanes,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs2,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / 8;
    localparam int RD_CLKS = int'(max2(max2(clocks_for(T_AA_NS, CLK_NS), clocks_for(T_RC_NS, CLK_NS)),
                                       clocks_for(T_OE_NS, CLK_NS)));
    localparam int WR_CLKS = int'(max2(max2(clocks_for(T_WP_NS, CLK_NS), 1 + clocks_for(T_DW_NS, CLK_NS)),
                                       max2(clocks_for(T_WC_NS, CLK_NS), clocks_for(T_AW_NS, CLK_NS))));
    localparam int CNT_W   = $clog2(int'(max2(RD_CLKS, WR_CLKS)) + 1);

    logic             accept, load, last, capture, wr_q;
    logic [CNT_W-1:0] load_val;
    logic [LANES-1:0] lanes_q, sel_n;

    sram_if_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
        .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
        .capture(capture), .mem_dq_in(mem_dq_in), .addr_q(mem_addr),
        .wr_q(wr_q), .lanes_q(lanes_q), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
    );

    sram_seq_fsm #(.LANES(LANES), .CNT_W(CNT_W), .RD_CLKS(RD_CLKS), .WR_CLKS(WR_CLKS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lanes(req_lanes),
        .wr_q(wr_q), .lanes_q(lanes_q), .last(last), .accept(accept),
        .load(load), .load_val(load_val), .capture(capture), .ready(req_ready),
        .done(rsp_done), .cs_n(mem_cs_n), .cs2(mem_cs2), .wr_n(mem_wr_n),
        .rd_n(mem_rd_n), .sel_n(sel_n), .dq_oe(mem_dq_oe)
    );

    assign mem_lo_n = sel_n[0];
    assign mem_hi_n = sel_n[LANES-1];

    // Quiet means no strobe that could open a cycle on the memory.
    logic pins_quiet;
    assign pins_quiet = mem_cs_n && !mem_cs2 && mem_wr_n && mem_lo_n && mem_hi_n;

    // R3
    addr_move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |-> (pins_quiet && $past(pins_quiet)));
endmodule

// File: tb/sram_if_ctrl_tb.sv
`timescale 1ns/1ps
module sram_if_ctrl_tb_top;
    localparam int CLK_NS = 5;
    // Expected phase lengths from the requirement formulas at default timings.
    localparam int RD_EXP = 11;   // max(ceil(55/5), ceil(55/5), ceil(30/5))
    localparam int WR_EXP = 11;   // max(ceil(45/5), 1+ceil(25/5), ceil(55/5), ceil(50/5))

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_lanes = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs2, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [1:0] cur_lanes = '0;

    always #2.5 clk = ~clk;

    sram_if_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_lo_n(mem_lo_n),
        .mem_hi_n(mem_hi_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model (bench side) ----------------
    logic [15:0] mem_arr [int];
    bit          pend_v = 1'b0, pend_oe = 1'b0;
    logic [16:0] pend_a;
    logic [1:0]  pend_l;
    logic [15:0] pend_d;

    function automatic logic [15:0] arr_rd(input logic [16:0] a);
        return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : 16'h0000;
    endfunction

    // Write commits at the end of the strobe overlap; read drives selected lanes.
    always @(negedge clk) begin
        logic sel;
        logic [15:0] w, r;
        sel = !mem_cs_n && mem_cs2;
        if (sel && !mem_wr_n) begin
            pend_v = 1'b1; pend_a = mem_addr; pend_l = {!mem_hi_n, !mem_lo_n};
            pend_d = mem_dq_out; pend_oe = mem_dq_oe;
        end else if (pend_v) begin
            // R8: data must be driven at the end of the write pulse
            check(pend_oe, "R8", "data driven at write end", pend_oe, 1);
            w = arr_rd(pend_a);
            if (pend_l[0]) w[7:0]  = pend_d[7:0];
            if (pend_l[1]) w[15:8] = pend_d[15:8];
            mem_arr[int'(pend_a)] = w;
            pend_v = 1'b0;
        end
        r = arr_rd(mem_addr);
        mem_dq_in <= (sel && !mem_rd_n && mem_wr_n) ?
                     {mem_hi_n ? 8'h00 : r[15:8], mem_lo_n ? 8'h00 : r[7:0]} : 16'h0000;
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit wr; logic [15:0] exp; } item_t;
    item_t sb_q[$];
    logic [15:0] shadow [int];

    function automatic logic [15:0] sh_rd(input logic [16:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    endfunction

    // Monitor: pop an expected item at each completion and compare read data.
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "done without pending item", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (!it.wr) check(rsp_rdata == it.exp, "R5", "read data", rsp_rdata, it.exp);
            end
        end
    end

    // ---------------- pin monitors ----------------
    int wr_lo = 0, rd_lo = 0, oe_hi = 0;
    bit sel_bad = 1'b0, lane_bad = 1'b0;
    logic [16:0] prev_addr = '0;
    bit prev_quiet = 1'b1;

    always @(negedge clk) begin
        bit quiet;
        if (rst_n) begin
            quiet = mem_cs_n && !mem_cs2 && mem_wr_n && mem_lo_n && mem_hi_n;
            if (mem_addr != prev_addr)
                // R3: address moves only between quiet cycles
                check(quiet && prev_quiet, "R3", "strobes quiet across address change",
                      {prev_quiet, quiet}, 2'b11);
            if (!mem_wr_n && !mem_rd_n) check(1'b0, "R10", "write and read strobe overlap", 1, 0);
            if (mem_dq_oe && !mem_rd_n) check(1'b0, "R8", "drive while output enabled", 1, 0);
            if (!mem_wr_n || !mem_rd_n) begin
                if (!(!mem_cs_n && mem_cs2)) sel_bad = 1'b1;
                if ({mem_hi_n, mem_lo_n} != ~cur_lanes) lane_bad = 1'b1;
            end else if (!mem_cs_n || mem_cs2) begin
                check(1'b0, "R4", "selected without strobe", {mem_cs_n, mem_cs2}, 2'b10);
            end
            if (!mem_wr_n) wr_lo++;
            else if (wr_lo != 0) begin
                check(wr_lo == WR_EXP, "R7", "write pulse clocks", wr_lo, WR_EXP);
                check(!sel_bad, "R4", "chip selected through write", sel_bad, 0);
                check(!lane_bad, "R6", "lane selects during write", lane_bad, 0);
                wr_lo = 0; sel_bad = 0; lane_bad = 0;
            end
            if (!mem_rd_n) begin
                rd_lo++;
                if (!mem_wr_n) check(1'b0, "R5", "write strobe during read", 1, 0);
            end else if (rd_lo != 0) begin
                check(rd_lo == RD_EXP, "R5", "read strobe clocks", rd_lo, RD_EXP);
                check(!sel_bad, "R4", "chip selected through read", sel_bad, 0);
                check(!lane_bad, "R6", "lane selects during read", lane_bad, 0);
                rd_lo = 0; sel_bad = 0; lane_bad = 0;
            end
            if (mem_dq_oe) oe_hi++;
            else if (oe_hi != 0) begin
                check(oe_hi == WR_EXP, "R8", "drive window clocks", oe_hi, WR_EXP);
                oe_hi = 0;
            end
            prev_addr = mem_addr;
            prev_quiet = quiet;
        end
    end

    // ---------------- driver ----------------
    task automatic txn(input bit wr, input logic [16:0] a, input logic [1:0] ln, input logic [15:0] wd);
        item_t it;
        logic [15:0] s;
        int cyc;
        @(negedge clk);
        check(req_ready, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_lanes = ln; req_wdata = wd;
        cur_lanes = ln;
        s = sh_rd(a);
        if (wr) begin
            if (ln[0]) s[7:0]  = wd[7:0];
            if (ln[1]) s[15:8] = wd[15:8];
            shadow[int'(a)] = s;
            it.wr = 1'b1; it.exp = '0;
        end else begin
            it.wr = 1'b0;
            it.exp = {ln[1] ? s[15:8] : 8'h00, ln[0] ? s[7:0] : 8'h00};
        end
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0; req_lanes = '0;
        cyc = 1;
        // R2: busy after acceptance
        check(!req_ready, "R2", "ready low while busy", req_ready, 0);
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        // R5 / R7 latency, R9 completion pulse
        check(cyc == (wr ? WR_EXP + 3 : RD_EXP + 2), wr ? "R7" : "R5", "done latency",
              cyc, wr ? WR_EXP + 3 : RD_EXP + 2);
        @(negedge clk);
        check(!rsp_done, "R9", "done single cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready && !rsp_done && mem_cs_n && !mem_cs2 && mem_wr_n && mem_rd_n &&
              mem_lo_n && mem_hi_n && !mem_dq_oe, "R1", "pins during reset",
              {req_ready, rsp_done, mem_cs_n, mem_cs2, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n, mem_dq_oe},
              9'b1_0_1_0_1_1_1_1_0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_cs_n && !mem_cs2 && !mem_dq_oe, "R1", "pins after reset",
              {req_ready, mem_cs_n, mem_cs2, mem_dq_oe}, 4'b1100);

        // R2: request without lanes is ignored
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_lanes = 2'b00; req_wdata = 16'hDEAD;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req_ready && mem_cs_n && mem_wr_n && !rsp_done, "R2", "no-lane request ignored",
                  {req_ready, mem_cs_n, mem_wr_n, rsp_done}, 4'b1110);
        end
        req_valid = 1'b0;
        txn(1'b0, 17'h00042, 2'b11, '0);               // R2: still unwritten, reads zero

        txn(1'b1, 17'h00000, 2'b11, 16'hA5C3);
        txn(1'b0, 17'h00000, 2'b11, '0);               // R5 full word
        txn(1'b1, 17'h1FFFF, 2'b11, 16'h0F0F);         // top address
        txn(1'b0, 17'h1FFFF, 2'b11, '0);
        txn(1'b1, 17'h00000, 2'b01, 16'hFF11);         // R6 lower lane only
        txn(1'b0, 17'h00000, 2'b11, '0);
        txn(1'b1, 17'h00000, 2'b10, 16'h77EE);         // R6 upper lane only
        txn(1'b0, 17'h00000, 2'b10, '0);               // upper read: lower reads zero
        txn(1'b0, 17'h00000, 2'b01, '0);               // lower read: upper reads zero
        for (int k = 1; k < 9; k++) begin
            txn(1'b1, 17'(k * 4099), 2'b11, 16'(k * 16'h1357));
            txn(1'b0, 17'(k * 4099), 2'b11, '0);
        end
        txn(1'b0, 17'h00123, 2'b11, '0);               // never written
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9", "all transactions completed", sb_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule